// File: doc/BRIEF.md
# Synchronous Read Output Stage with Two-Edge Deselect

This block sits between the storage array of a synchronous SRAM and its data pins. It decides when read data reaches the output bus and when the bus drivers are switched on. A static mode input picks one of two timings. In flow-through timing the array data goes straight to the output. In pipelined timing the data first passes through a rising-edge register. The select state of the port runs through the same number of stages as the data. In pipelined timing a deselect therefore lets the drivers run for one more full cycle, and they turn off only after the second rising edge.

A new access begins on a cycle with the address strobe high. On that cycle the port is selected only if both the main enable and the auxiliary enable are high. Any other enable combination on a strobe cycle is a deselect. On a cycle without the strobe, the previous selection continues, and the auxiliary enable is not looked at. The array is expected to present `arr_rdata` in the cycle after the strobe edge. An active-low output enable gates the drivers combinationally, with no clock involved. A sleep input that is sampled high on two edges in a row puts the port into a retained, quiet state. Unused sleep inputs must be tied low.

The power FSM has three states. PW_AWAKE goes to PW_ENTER when sleep is sampled high. PW_ENTER goes to PW_ASLEEP when sleep is still high, and back to PW_AWAKE when sleep is low. PW_ASLEEP goes back to PW_AWAKE when sleep is sampled low. The select FSM has two states. SEL_OFF goes to SEL_ON on a strobe with both enables high. SEL_ON goes to SEL_OFF on a strobe with either enable low. Both select stages are forced to SEL_OFF on the edge that enters PW_ASLEEP, and on every edge taken while in PW_ASLEEP.

Top module: `rop_read_out`

## Requirements
- R1: While reset is active and in the first cycle after it, `dout_drive` is 0 and the power FSM is in PW_AWAKE.
- R2: With `mode_pipe`=0, a strobe with both enables high at edge k drives `dout_drive`=1 after edge k, and `dout` equals the present `arr_rdata` combinationally.
- R3: With `mode_pipe`=1, a selecting strobe at edge k drives `dout_drive`=1 only after edge k+1, and `dout` equals the `arr_rdata` value sampled at the latest edge.
- R4: With `mode_pipe`=1, a deselecting strobe at edge k keeps `dout_drive`=1 after edge k and clears it after edge k+1.
- R5: With `mode_pipe`=0, a deselecting strobe at edge k clears `dout_drive` after edge k.
- R6: `ce_aux` is sampled only on strobe cycles. A strobe with `ce_aux`=0 deselects the port, and `ce_aux`=0 on a cycle without the strobe leaves the selection unchanged.
- R7: On cycles without the strobe the previous selection continues in both modes, whatever the value of `ce_main`.
- R8: `oe_n`=1 forces `dout_drive`=0 within the same cycle, and `oe_n`=0 restores it within the same cycle, without any clock edge.
- R9: Sleep sampled high at edges k and k+1 forces `dout_drive`=0 after edge k+1. A sleep pulse sampled high at only one edge leaves the outputs unaffected.
- R10: Strobes sampled while asleep are ignored. After sleep is released the port stays deselected until a new selecting strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pipe | input | 1 | 0 = flow-through timing, 1 = pipelined timing (static) |
| addr_stb | input | 1 | Address strobe; starts a new access |
| ce_main | input | 1 | Main chip enable, active high, sampled on strobe cycles |
| ce_aux | input | 1 | Auxiliary chip enable, active high, sampled only on strobe cycles |
| arr_rdata | input | DATA_W | Read data from the storage array |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| dout | output | DATA_W | Data toward the output bus |
| dout_drive | output | 1 | Bus driver enable, active high |

## Verification
The bench goes after the edge on which the drivers turn off after a deselect in each mode. A design that did not delay deselects as far as reads would cut off pipelined data one cycle early, and one that delayed them in flow-through mode would drive for a cycle too long. It sends strobes with the auxiliary enable low, and toggles that enable on cycles without a strobe. A design that sampled it on every cycle would drop an ongoing access. It also sends a one-edge sleep pulse that must not cause sleep, and strobes during sleep that must not come back on wake-up. A design with a one-stage sleep entry, or one that latched commands while asleep, would show the drivers off too early or on with no new strobe. Toggling the output enable between edges catches a design that registers it.

// File: rtl/rop_pkg.sv
package rop_pkg;

    typedef enum logic [1:0] {
        PW_AWAKE  = 2'd0,
        PW_ENTER  = 2'd1,
        PW_ASLEEP = 2'd2
    } pw_state_t;

    typedef enum logic {
        SEL_OFF = 1'b0,
        SEL_ON  = 1'b1
    } sel_state_t;

endpackage

// File: rtl/rop_power_fsm.sv
module rop_power_fsm
    import rop_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep,
    output pw_state_t pw_q,
    output logic      awake,
    output logic      quiesce
);

    pw_state_t pw_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pw_q <= PW_AWAKE;
        else        pw_q <= pw_d;
    end

    always_comb begin
        pw_d = pw_q;
        unique case (pw_q)
            PW_AWAKE:  pw_d = sleep ? PW_ENTER  : PW_AWAKE;
            PW_ENTER:  pw_d = sleep ? PW_ASLEEP : PW_AWAKE;
            PW_ASLEEP: pw_d = sleep ? PW_ASLEEP : PW_AWAKE;
            default:   pw_d = PW_AWAKE;
        endcase
    end

    // Select stages are cleared on the edge entering sleep and while asleep.
    always_comb begin
        awake   = (pw_q != PW_ASLEEP);
        quiesce = (pw_q == PW_ASLEEP) || (pw_d == PW_ASLEEP);
    end

endmodule

// File: rtl/rop_select_pipe.sv
module rop_select_pipe
    import rop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       quiesce,
    input  logic       addr_stb,
    input  logic       ce_main,
    input  logic       ce_aux,
    output sel_state_t sel_early,
    output sel_state_t sel_late
);

    sel_state_t early_d;
    logic       enables_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_early <= SEL_OFF;
            sel_late  <= SEL_OFF;
        end else if (quiesce) begin
            sel_early <= SEL_OFF;
            sel_late  <= SEL_OFF;
        end else begin
            sel_early <= early_d;
            sel_late  <= sel_early;
        end
    end

    always_comb begin
        enables_ok = ce_main && ce_aux;
        early_d    = sel_early;
        unique case (sel_early)
            SEL_OFF: if (addr_stb && enables_ok)  early_d = SEL_ON;
            SEL_ON:  if (addr_stb && !enables_ok) early_d = SEL_OFF;
            default: early_d = SEL_OFF;
        endcase
    end

endmodule

// File: rtl/rop_out_stage.sv
module rop_out_stage
    import rop_pkg::*;
#(
    parameter int DATA_W = 36
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              mode_pipe,
    input  logic [DATA_W-1:0] arr_rdata,
    input  sel_state_t        sel_early,
    input  sel_state_t        sel_late,
    input  logic              oe_n,
    input  logic              awake,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drive
);

    logic [DATA_W-1:0] data_q;
    logic              sel_live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          data_q <= '0;
        else if (capture_en) data_q <= arr_rdata;
    end

    always_comb begin
        dout       = mode_pipe ? data_q : arr_rdata;
        sel_live   = mode_pipe ? (sel_late == SEL_ON) : (sel_early == SEL_ON);
        dout_drive = sel_live && !oe_n && awake;
    end

endmodule

// File: rtl/rop_read_out.sv
module rop_read_out
    import rop_pkg::*;
#(
    parameter int DATA_W = 36
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pipe,
    input  logic              addr_stb,
    input  logic              ce_main,
    input  logic              ce_aux,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drive
);

    pw_state_t  pw_q;
    logic       awake;
    logic       quiesce;
    sel_state_t sel_early;
    sel_state_t sel_late;

    rop_power_fsm u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (sleep),
        .pw_q    (pw_q),
        .awake   (awake),
        .quiesce (quiesce)
    );

    rop_select_pipe u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .quiesce   (quiesce),
        .addr_stb  (addr_stb),
        .ce_main   (ce_main),
        .ce_aux    (ce_aux),
        .sel_early (sel_early),
        .sel_late  (sel_late)
    );

    rop_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (awake),
        .mode_pipe  (mode_pipe),
        .arr_rdata  (arr_rdata),
        .sel_early  (sel_early),
        .sel_late   (sel_late),
        .oe_n       (oe_n),
        .awake      (awake),
        .dout       (dout),
        .dout_drive (dout_drive)
    );

endmodule

// File: rtl/rop_read_out_chk.sv
module rop_read_out_chk #(
    parameter int DATA_W = 36
)(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_pipe,
    input logic              addr_stb,
    input logic              ce_main,
    input logic              ce_aux,
    input logic [DATA_W-1:0] arr_rdata,
    input logic              oe_n,
    input logic              sleep,
    input logic [DATA_W-1:0] dout,
    input logic              dout_drive
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R3
    pipe_data_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (mode_pipe && $past(mode_pipe) && dout_drive) |-> (dout == $past(arr_rdata)));

    // R4
    pipe_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb && !ce_main) |=> ##1 (!dout_drive || !mode_pipe));

    // R5
    flow_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb && !(ce_main && ce_aux)) |=> (!dout_drive || mode_pipe));

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_drive);

    // R9
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (sleep && $past(sleep)) |=> !dout_drive);

endmodule

bind rop_read_out rop_read_out_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_pipe  (mode_pipe),
    .addr_stb   (addr_stb),
    .ce_main    (ce_main),
    .ce_aux     (ce_aux),
    .arr_rdata  (arr_rdata),
    .oe_n       (oe_n),
    .sleep      (sleep),
    .dout       (dout),
    .dout_drive (dout_drive)
);

// File: tb/tb_rop_read_out.sv
module tb_rop_read_out;

    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_pipe = 1'b0;
    logic         addr_stb = 1'b0;
    logic         ce_main = 1'b0;
    logic         ce_aux = 1'b0;
    logic [W-1:0] arr_rdata = '0;
    logic         oe_n = 1'b0;
    logic         sleep = 1'b0;
    logic [W-1:0] dout;
    logic         dout_drive;

    int errors = 0;
    int checks = 0;
    int cyc_n  = 0;
    bit done   = 0;
    string tag = "R1";

    // reference model: 0 awake, 1 entering, 2 asleep
    int           m_pw = 0;
    bit           m_hist[$];
    bit           m_cur = 0;
    logic [W-1:0] m_data = '0;

    rop_read_out #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .addr_stb(addr_stb),
        .ce_main(ce_main), .ce_aux(ce_aux), .arr_rdata(arr_rdata), .oe_n(oe_n),
        .sleep(sleep), .dout(dout), .dout_drive(dout_drive)
    );

    always #10 clk = ~clk;

    task automatic check(string t, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", t, act, exp, cyc_n);
        end
    endtask

    function automatic bit prior_sel();
        return (m_hist.size() > 0) ? m_hist[m_hist.size()-1] : 1'b0;
    endfunction

    function automatic bit exp_drive();
        bit s;
        s = mode_pipe ? prior_sel() : m_cur;
        return s && !oe_n && (m_pw != 2);
    endfunction

    task automatic compare();
        check(tag, {{(W-1){1'b0}}, dout_drive}, {{(W-1){1'b0}}, exp_drive()});
        if (exp_drive() && dout_drive)
            check(tag, dout, mode_pipe ? m_data : arr_rdata);
    endtask

    task automatic model_edge();
        int nxt;
        case (m_pw)
            0:       nxt = sleep ? 1 : 0;
            1:       nxt = sleep ? 2 : 0;
            default: nxt = sleep ? 2 : 0;
        endcase
        if (m_pw == 2 || nxt == 2) begin
            m_hist.push_back(1'b0);
            m_cur = 1'b0;
        end else begin
            m_hist.push_back(m_cur);
            if (addr_stb) m_cur = ce_main && ce_aux;
        end
        if (m_hist.size() > 4) void'(m_hist.pop_front());
        if (m_pw != 2) m_data = arr_rdata;
        m_pw = nxt;
    endtask

    task automatic cyc(bit stb, bit cm, bit ca, bit oe, bit sl);
        @(negedge clk);
        addr_stb  = stb;
        ce_main   = cm;
        ce_aux    = ca;
        oe_n      = oe;
        sleep     = sl;
        arr_rdata = W'(cyc_n * 40503 + 17) ^ {W{cyc_n[0]}};
        #2;
        compare();
        @(posedge clk);
        model_edge();
        cyc_n++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        check("R1", {{(W-1){1'b0}}, dout_drive}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2: flow-through read
        tag = "R2";
        mode_pipe = 1'b0;
        cyc(1, 1, 1, 0, 0);
        @(negedge clk); #2;
        check("R2", {{(W-1){1'b0}}, dout_drive}, {{(W-1){1'b0}}, 1'b1});
        check("R2", dout, arr_rdata);
        // R7: continuation with ce_main low and no strobe
        tag = "R7";
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        // R5: flow deselect drops drive after one edge
        tag = "R5";
        cyc(1, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        // R6: strobe with ce_aux low deselects; without strobe it is ignored
        tag = "R6";
        cyc(1, 1, 1, 0, 0);
        cyc(0, 1, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        cyc(1, 1, 0, 0, 0);
        cyc(0, 1, 1, 0, 0);
        cyc(1, 1, 1, 0, 0);
        // R8: asynchronous output enable inside one cycle
        tag = "R8";
        @(negedge clk); #2;
        oe_n = 1'b1; #1;
        check("R8", {{(W-1){1'b0}}, dout_drive}, '0);
        oe_n = 1'b0; #1;
        check("R8", {{(W-1){1'b0}}, dout_drive}, {{(W-1){1'b0}}, 1'b1});
        @(posedge clk);
        model_edge();
        cyc_n++;
        cyc(0, 1, 1, 1, 0);
        cyc(1, 0, 0, 0, 0);
        idle(2);

        // R3: pipelined read
        tag = "R3";
        mode_pipe = 1'b1;
        idle(2);
        cyc(1, 1, 1, 0, 0);
        @(negedge clk); #2;
        check("R3", {{(W-1){1'b0}}, dout_drive}, '0);
        @(posedge clk);
        model_edge();
        cyc_n++;
        cyc(0, 0, 0, 0, 0);
        cyc(1, 1, 1, 0, 0);
        cyc(0, 1, 0, 0, 0);
        // R4: pipelined deselect holds drive one extra cycle
        tag = "R4";
        cyc(1, 0, 1, 0, 0);
        @(negedge clk); #2;
        check("R4", {{(W-1){1'b0}}, dout_drive}, {{(W-1){1'b0}}, 1'b1});
        @(posedge clk);
        model_edge();
        cyc_n++;
        cyc(0, 0, 0, 0, 0);
        cyc(1, 1, 1, 0, 0);
        cyc(1, 1, 0, 0, 0);
        cyc(1, 1, 1, 0, 0);
        cyc(1, 0, 1, 0, 0);
        cyc(1, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);

        // R9: one-edge sleep pulse has no effect, two edges enter sleep
        tag = "R9";
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        @(negedge clk); #2;
        check("R9", {{(W-1){1'b0}}, dout_drive}, '0);
        @(posedge clk);
        model_edge();
        cyc_n++;
        // R10: strobes while asleep are ignored
        tag = "R10";
        cyc(1, 1, 1, 0, 1);
        cyc(1, 1, 1, 0, 1);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0);
        cyc(0, 1, 1, 0, 0);
        @(negedge clk); #2;
        check("R10", {{(W-1){1'b0}}, dout_drive}, '0);
        @(posedge clk);
        model_edge();
        cyc_n++;
        cyc(1, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        // flow-through sleep entry as well
        mode_pipe = 1'b0;
        tag = "R9";
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0);
        tag = "R10";
        cyc(0, 0, 0, 0, 0);
        cyc(1, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule